// File: doc/BRIEF.md
# Li-Ion Charge Phase Sequencer

This block walks a switching battery charger through its charge phases. It reads digitized comparator flags from the analog front end, a fault summary, the battery temperature zone and a one-minute tick. From these it keeps the active phase and drives a current-limit target and a termination-voltage code to the regulation loop. It also raises one-cycle events when either of its two minute-based timeouts expires.

The four phases are, in encoding order: waiting for valid conditions (0), pre-charge at a small fixed current (1), full constant-current charge (2), and end-of-charge regulation at the termination voltage (3). Each of the four temperature zones has its own current and voltage fields, and the block picks the fields for the present zone. Restart hysteresis comes from the restart flag: after charging ends, a new cycle starts only once the battery has fallen below the restart level. That level sits 100 mV under termination.

All control pins are plain levels. No data stream crosses the boundary, so the block has no valid/ready handshake. The pre-charge comparator flag is expected to carry its own 70 mV hysteresis. Outside fault logic is expected to latch a full-charge timeout, if it must stop charging until software intervenes.

Top module: `li_chg_sequencer`

## Requirements
- R1: While reset is held or `enable` is low, `phase` is 0 (waiting) and `ilim_ma` is 0.
- R2: From phase 0 the block moves to pre-charge (1) only when `below_restart` is 1, `enable` is 1, `fault_flags` is all zero and the selected termination code is valid. Otherwise it stays in phase 0.
- R3: Pre-charge moves to full charge (2) when `above_pre` is 1. Full charge or end-of-charge returns to pre-charge when `above_pre` drops to 0.
- R4: Full charge moves to end-of-charge (3) when both `at_term` and `below_eoc` are 1. If only one of them is 1, it stays in full charge.
- R5: In end-of-charge, with `at_term` at 1, charging ends (phase 0) when the selected top-off flag is 1. `cfg_topend_sel` 0 selects `below_top_lo` (25 mA level) and 1 selects `below_top_hi` (92 mA level). The other flag is ignored.
- R6: Any nonzero `fault_flags` bit returns the block to phase 0 on the next cycle and clears both timers.
- R7: The full-charge timer counts `minute_tick` pulses while the phase is 2 or 3. It expires when the count reaches 200 × `cfg_fc_to`, and code 0 disables it. On expiry `fc_expired` is high for one cycle and the phase returns to 0 on the next cycle.
- R8: The top-off timer counts ticks while the phase is 3. It expires at 20 × `cfg_top_to`, so code 0 expires on the first cycle of phase 3, and code 7 disables it. On expiry `top_expired` is high for one cycle, in phase 3, and the phase then returns to 0.
- R9: `ilim_ma` is 0 in phase 0 and follows the `cfg_pre_i` map in phase 1 (00=50, 01=100, 10=185, 11=370 mA). `eoc_ma` follows the same map from `cfg_eoc_i`.
- R10: `vterm_code` is the 3-bit field of `cfg_vterm` at bits [3z+2:3z] for zone z. The value 7 is invalid and forces phase 0.
- R11: In phases 2 and 3, `ilim_ma` comes from the 4-bit field of `cfg_imax` at bits [4z+3:4z] for zone z. Code 0 gives 50 mA and code n gives 100·n mA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Charger enable; low holds phase 0 |
| fault_flags | input | FLT_W | Fault and warning flags; any bit set aborts charging |
| zone | input | ZW | Battery temperature zone, 0 coldest to 3 warmest |
| above_pre | input | 1 | Battery above the pre-charge threshold |
| at_term | input | 1 | Battery at termination voltage |
| below_eoc | input | 1 | Charge current under the end-of-charge level |
| below_top_lo | input | 1 | Charge current under the 25 mA top-off level |
| below_top_hi | input | 1 | Charge current under the 92 mA top-off level |
| below_restart | input | 1 | Battery under the restart level |
| minute_tick | input | 1 | One-cycle pulse each minute |
| cfg_vterm | input | ZONES*3 | Termination-voltage code per zone |
| cfg_imax | input | ZONES*4 | Full-charge current code per zone |
| cfg_pre_i | input | 2 | Pre-charge current code |
| cfg_eoc_i | input | 2 | End-of-charge current code |
| cfg_topend_sel | input | 1 | Top-off end level select |
| cfg_fc_to | input | 3 | Full-charge timeout code |
| cfg_top_to | input | 3 | Top-off timeout code |
| phase | output | 2 | Active phase |
| ilim_ma | output | 11 | Current limit in mA |
| eoc_ma | output | 11 | End-of-charge current level in mA |
| vterm_code | output | 3 | Selected termination-voltage code |
| fc_expired | output | 1 | Full-charge timeout event |
| top_expired | output | 1 | Top-off timeout event |

## Verification
The hardest cases to reach are the timer limits. The full-charge timer needs 200 ticks inside charge phases, and it must be shown cleared after a fault. The stimulus first holds full charge for 150 ticks, injects a fault, and re-enters full charge. It then confirms that 199 further ticks give no expiry and that tick 200 does. This is the only way to show the count restarted from zero. End-of-charge is reached by setting the termination and end-of-charge flags together in full charge. A top-off code of 0 is then used to see expiry in the very cycle the phase is entered.

// File: rtl/chg_seq_pkg.sv
package chg_seq_pkg;
  localparam int MA_W = 11;
  localparam int VT_W = 3;
  localparam int IM_W = 4;
  localparam int TO_W = 3;

  typedef enum logic [1:0] {
    PH_INIT = 2'd0,
    PH_PRE  = 2'd1,
    PH_FULL = 2'd2,
    PH_EOC  = 2'd3
  } phase_t;

  // Shared two-bit current map for pre-charge and end-of-charge levels
  function automatic logic [MA_W-1:0] small_i_ma(input logic [1:0] c);
    case (c)
      2'd0:    return MA_W'(50);
      2'd1:    return MA_W'(100);
      2'd2:    return MA_W'(185);
      default: return MA_W'(370);
    endcase
  endfunction

  // Full-charge current: code 0 is 50 mA, others are 100 mA steps
  function automatic logic [MA_W-1:0] big_i_ma(input logic [IM_W-1:0] c);
    if (c == '0) return MA_W'(50);
    return MA_W'(c) * MA_W'(100);
  endfunction
endpackage

// File: rtl/chg_zone_sel.sv
module chg_zone_sel import chg_seq_pkg::*; #(
  parameter int ZONES = 4,
  localparam int ZW = $clog2(ZONES)
) (
  input  logic [ZW-1:0]         zone,
  input  logic [ZONES*VT_W-1:0] cfg_vterm,
  input  logic [ZONES*IM_W-1:0] cfg_imax,
  output logic [VT_W-1:0]       vterm_code,
  output logic [IM_W-1:0]       imax_code,
  output logic                  vterm_bad
);
  logic [VT_W-1:0] vt_arr [ZONES];
  logic [IM_W-1:0] im_arr [ZONES];

  for (genvar z = 0; z < ZONES; z++) begin : g_zone
    assign vt_arr[z] = cfg_vterm[z*VT_W +: VT_W];
    assign im_arr[z] = cfg_imax[z*IM_W +: IM_W];
  end

  assign vterm_code = vt_arr[zone];
  assign imax_code  = im_arr[zone];
  assign vterm_bad  = &vterm_code;
endmodule

// File: rtl/chg_min_timer.sv
module chg_min_timer #(
  parameter int CODE_W   = 3,
  parameter int STEP     = 200,
  parameter int DIS_CODE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic [CODE_W-1:0] code,
  output logic              expired
);
  localparam int MAX_MIN = ((1 << CODE_W) - 1) * STEP;
  localparam int CNT_W   = $clog2(MAX_MIN + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit = CNT_W'(code) * CNT_W'(STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (!run)               cnt <= '0;
    else if (tick && cnt < limit) cnt <= cnt + 1'b1;
  end

  assign expired = run && (code != CODE_W'(DIS_CODE)) && (cnt >= limit);
endmodule

// File: rtl/chg_phase_fsm.sv
module chg_phase_fsm import chg_seq_pkg::*; (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   enable,
  input  logic   fault_any,
  input  logic   vterm_bad,
  input  logic   above_pre,
  input  logic   at_term,
  input  logic   below_eoc,
  input  logic   topend_hit,
  input  logic   below_restart,
  input  logic   fc_exp,
  input  logic   top_exp,
  output phase_t state
);
  phase_t nxt;
  logic   force_init;

  assign force_init = !enable || fault_any || vterm_bad;

  always_comb begin
    nxt = state;
    if (force_init) nxt = PH_INIT;
    else begin
      case (state)
        PH_INIT: if (below_restart) nxt = PH_PRE;
        PH_PRE:  if (above_pre) nxt = PH_FULL;
        PH_FULL: begin
          if (fc_exp)                     nxt = PH_INIT;
          else if (!above_pre)            nxt = PH_PRE;
          else if (at_term && below_eoc)  nxt = PH_EOC;
        end
        default: begin
          if (fc_exp || top_exp)          nxt = PH_INIT;
          else if (!above_pre)            nxt = PH_PRE;
          else if (at_term && topend_hit) nxt = PH_INIT;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PH_INIT;
    else        state <= nxt;
  end

  a_r6_fault_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    fault_any |=> state == PH_INIT);
  a_r10_bad_vterm_holds: assert property (@(posedge clk) disable iff (!rst_n)
    vterm_bad |=> state == PH_INIT);
  a_r2_waits_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_INIT && !below_restart) |=> state == PH_INIT);
  a_r3_pre_to_full: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_PRE && above_pre && !force_init) |=> state == PH_FULL);
  a_r4_full_to_eoc: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_FULL && !force_init && !fc_exp && above_pre && at_term && below_eoc)
    |=> state == PH_EOC);
  a_r5_topoff_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_EOC && at_term && topend_hit) |=> state == PH_INIT);
endmodule

// File: rtl/li_chg_sequencer.sv
module li_chg_sequencer import chg_seq_pkg::*; #(
  parameter int ZONES    = 4,
  parameter int FLT_W    = 8,
  parameter int FC_STEP  = 200,
  parameter int TOP_STEP = 20,
  localparam int ZW = $clog2(ZONES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enable,
  input  logic [FLT_W-1:0]      fault_flags,
  input  logic [ZW-1:0]         zone,
  input  logic                  above_pre,
  input  logic                  at_term,
  input  logic                  below_eoc,
  input  logic                  below_top_lo,
  input  logic                  below_top_hi,
  input  logic                  below_restart,
  input  logic                  minute_tick,
  input  logic [ZONES*VT_W-1:0] cfg_vterm,
  input  logic [ZONES*IM_W-1:0] cfg_imax,
  input  logic [1:0]            cfg_pre_i,
  input  logic [1:0]            cfg_eoc_i,
  input  logic                  cfg_topend_sel,
  input  logic [TO_W-1:0]       cfg_fc_to,
  input  logic [TO_W-1:0]       cfg_top_to,
  output logic [1:0]            phase,
  output logic [MA_W-1:0]       ilim_ma,
  output logic [MA_W-1:0]       eoc_ma,
  output logic [VT_W-1:0]       vterm_code,
  output logic                  fc_expired,
  output logic                  top_expired
);
  phase_t          state;
  logic [IM_W-1:0] imax_code;
  logic            vterm_bad;
  logic            topend_hit;
  logic            fc_run, top_run;

  chg_zone_sel #(.ZONES(ZONES)) u_zone (
    .zone(zone), .cfg_vterm(cfg_vterm), .cfg_imax(cfg_imax),
    .vterm_code(vterm_code), .imax_code(imax_code), .vterm_bad(vterm_bad)
  );

  assign fc_run  = (state == PH_FULL) || (state == PH_EOC);
  assign top_run = (state == PH_EOC);

  chg_min_timer #(.CODE_W(TO_W), .STEP(FC_STEP), .DIS_CODE(0)) u_fc_tmr (
    .clk(clk), .rst_n(rst_n), .run(fc_run), .tick(minute_tick),
    .code(cfg_fc_to), .expired(fc_expired)
  );

  chg_min_timer #(.CODE_W(TO_W), .STEP(TOP_STEP), .DIS_CODE((1 << TO_W) - 1)) u_top_tmr (
    .clk(clk), .rst_n(rst_n), .run(top_run), .tick(minute_tick),
    .code(cfg_top_to), .expired(top_expired)
  );

  assign topend_hit = cfg_topend_sel ? below_top_hi : below_top_lo;

  chg_phase_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .enable(enable), .fault_any(|fault_flags),
    .vterm_bad(vterm_bad), .above_pre(above_pre), .at_term(at_term),
    .below_eoc(below_eoc), .topend_hit(topend_hit), .below_restart(below_restart),
    .fc_exp(fc_expired), .top_exp(top_expired), .state(state)
  );

  always_comb begin
    case (state)
      PH_INIT: ilim_ma = '0;
      PH_PRE:  ilim_ma = small_i_ma(cfg_pre_i);
      default: ilim_ma = big_i_ma(imax_code);
    endcase
  end

  assign eoc_ma = small_i_ma(cfg_eoc_i);
  assign phase  = state;

  a_r7_fc_expiry_stops: assert property (@(posedge clk) disable iff (!rst_n)
    fc_expired |=> phase == PH_INIT);
  a_r8_top_expiry_in_eoc: assert property (@(posedge clk) disable iff (!rst_n)
    top_expired |-> phase == PH_EOC);
  a_r8_top_expiry_stops: assert property (@(posedge clk) disable iff (!rst_n)
    top_expired |=> phase == PH_INIT);
endmodule

// File: tb/sim_li_chg_sequencer.sv
`timescale 1ns/100ps
module sim_li_chg_sequencer;
  logic clk = 0;
  logic rst_n = 0;
  always #2.5 clk = ~clk;

  logic        enable = 0;
  logic [7:0]  fault_flags = '0;
  logic [1:0]  zone = 2'd1;
  logic        above_pre = 0, at_term = 0, below_eoc = 0;
  logic        below_top_lo = 0, below_top_hi = 0, below_restart = 0, minute_tick = 0;
  logic [11:0] cfg_vterm = {3'd6, 3'd5, 3'd3, 3'd1};
  logic [15:0] cfg_imax  = {4'd0, 4'd15, 4'd10, 4'd2};
  logic [1:0]  cfg_pre_i = 2'd2, cfg_eoc_i = 2'd1;
  logic        cfg_topend_sel = 0;
  logic [2:0]  cfg_fc_to = 3'd1, cfg_top_to = 3'd1;
  logic [1:0]  phase;
  logic [10:0] ilim_ma, eoc_ma;
  logic [2:0]  vterm_code;
  logic        fc_expired, top_expired;

  li_chg_sequencer u0 (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    logic [1:0]  ph;
    logic [10:0] ma;
    logic        fce;
    logic        toe;
    string       tag;
  } exp_t;
  exp_t q[$];

  // Driver: record what the next edge must produce, then move to the next falling edge
  task automatic cyc(input logic [1:0] ph, input int ma, input logic fce, input logic toe, input string tag);
    exp_t e;
    e.ph = ph; e.ma = 11'(ma); e.fce = fce; e.toe = toe; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: compare shortly after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, " phase"}, phase, e.ph);
        chk({e.tag, " ilim"}, ilim_ma, e.ma);
        chk({e.tag, " fc_expired"}, fc_expired, e.fce);
        chk({e.tag, " top_expired"}, top_expired, e.toe);
      end
    end
  end

  initial begin
    #900000;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset phase", phase, 0);
    chk("R1 reset ilim", ilim_ma, 0);
    chk("R10 zone1 vterm", vterm_code, 3);
    chk("R9 eoc map 01", eoc_ma, 100);
    rst_n = 1;
    @(negedge clk);
    below_restart = 1;
    cyc(0, 0, 0, 0, "R1 enable low");
    enable = 1; below_restart = 0;
    cyc(0, 0, 0, 0, "R2 above restart");
    fault_flags = 8'h01; below_restart = 1;
    cyc(0, 0, 0, 0, "R2 fault blocks");
    fault_flags = '0;
    cyc(1, 185, 0, 0, "R2 start pre");
    above_pre = 1;
    cyc(2, 1000, 0, 0, "R3 pre to full");
    zone = 2'd2;
    cyc(2, 1500, 0, 0, "R11 zone2 imax");
    chk("R10 zone2 vterm", vterm_code, 5);
    zone = 2'd3;
    cyc(2, 50, 0, 0, "R11 code0 50mA");
    zone = 2'd0;
    cyc(2, 200, 0, 0, "R11 zone0 imax");
    chk("R10 zone0 vterm", vterm_code, 1);
    zone = 2'd1;
    above_pre = 0;
    cyc(1, 185, 0, 0, "R3 fall back");
    above_pre = 1;
    cyc(2, 1000, 0, 0, "R3 full again");
    at_term = 1;
    cyc(2, 1000, 0, 0, "R4 term only");
    below_eoc = 1;
    cyc(3, 1000, 0, 0, "R4 enter eoc");
    // R8 top-off timer, 20 minutes
    minute_tick = 1;
    for (int k = 1; k < 20; k++) cyc(3, 1000, 0, 0, "R8 top counting");
    cyc(3, 1000, 0, 1, "R8 top expiry");
    minute_tick = 0; below_restart = 0;
    cyc(0, 0, 0, 0, "R8 after expiry");
    // R5 top-off end level select
    below_restart = 1;
    cyc(1, 185, 0, 0, "R5 setup pre");
    cyc(2, 1000, 0, 0, "R5 setup full");
    cyc(3, 1000, 0, 0, "R5 setup eoc");
    below_restart = 0; cfg_topend_sel = 1; below_top_lo = 1;
    cyc(3, 1000, 0, 0, "R5 other flag ignored");
    below_top_hi = 1;
    cyc(0, 0, 0, 0, "R5 92mA end");
    below_top_lo = 0; below_top_hi = 0; cfg_topend_sel = 0; below_restart = 1;
    cyc(1, 185, 0, 0, "R5 setup pre2");
    cyc(2, 1000, 0, 0, "R5 setup full2");
    cyc(3, 1000, 0, 0, "R5 setup eoc2");
    below_restart = 0; below_top_lo = 1;
    cyc(0, 0, 0, 0, "R5 25mA end");
    below_top_lo = 0;
    // R7 full-charge timer and R6 clearing
    at_term = 0; below_eoc = 0; below_restart = 1;
    cyc(1, 185, 0, 0, "R7 setup pre");
    cyc(2, 1000, 0, 0, "R7 setup full");
    minute_tick = 1;
    for (int k = 0; k < 150; k++) cyc(2, 1000, 0, 0, "R7 partial count");
    minute_tick = 0; fault_flags = 8'h10;
    cyc(0, 0, 0, 0, "R6 fault abort");
    fault_flags = '0;
    cyc(1, 185, 0, 0, "R6 resume pre");
    cyc(2, 1000, 0, 0, "R6 resume full");
    minute_tick = 1;
    for (int k = 1; k < 200; k++) cyc(2, 1000, 0, 0, "R6 timer cleared");
    cyc(2, 1000, 1, 0, "R7 fc expiry");
    minute_tick = 0;
    cyc(0, 0, 0, 0, "R7 after expiry");
    cfg_fc_to = 3'd0;
    cyc(1, 185, 0, 0, "R7 setup pre2");
    cyc(2, 1000, 0, 0, "R7 setup full2");
    minute_tick = 1;
    for (int k = 0; k < 250; k++) cyc(2, 1000, 0, 0, "R7 fc disabled");
    minute_tick = 0;
    // R8 disable code and zero code
    cfg_top_to = 3'd7; at_term = 1; below_eoc = 1;
    cyc(3, 1000, 0, 0, "R8 setup eoc");
    minute_tick = 1;
    for (int k = 0; k < 30; k++) cyc(3, 1000, 0, 0, "R8 top disabled");
    minute_tick = 0; fault_flags = 8'h80;
    cyc(0, 0, 0, 0, "R6 fault in eoc");
    fault_flags = '0; cfg_top_to = 3'd0;
    cyc(1, 185, 0, 0, "R8 setup pre");
    cyc(2, 1000, 0, 0, "R8 setup full");
    cyc(3, 1000, 0, 1, "R8 zero code immediate");
    cyc(0, 0, 0, 0, "R8 zero code exit");
    // R10 invalid termination code
    cfg_top_to = 3'd1; at_term = 0; below_eoc = 0;
    cyc(1, 185, 0, 0, "R10 setup pre");
    cyc(2, 1000, 0, 0, "R10 setup full");
    cfg_vterm[5:3] = 3'd7;
    cyc(0, 0, 0, 0, "R10 invalid aborts");
    cyc(0, 0, 0, 0, "R10 invalid holds");
    chk("R10 invalid code out", vterm_code, 7);
    cfg_vterm[5:3] = 3'd3;
    cyc(1, 185, 0, 0, "R10 valid resumes");
    cyc(2, 1000, 0, 0, "R1 setup full");
    enable = 0;
    cyc(0, 0, 0, 0, "R1 enable drop");
    // R9 pre-charge map
    enable = 1; above_pre = 0; cfg_pre_i = 2'd0;
    cyc(1, 50, 0, 0, "R9 pre 00");
    cfg_pre_i = 2'd1;
    cyc(1, 100, 0, 0, "R9 pre 01");
    cfg_pre_i = 2'd3;
    cyc(1, 370, 0, 0, "R9 pre 11");
    cfg_eoc_i = 2'd3;
    #1 chk("R9 eoc map 11", eoc_ma, 370);
    cfg_eoc_i = 2'd2;
    #1 chk("R9 eoc map 10", eoc_ma, 185);
    @(posedge clk); #3;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule